// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block carries the even-parity duties of a 32-bit multiplexed address/data bus target. In the cycle after the target puts read data on the bus, it supplies the parity bit and its output enable. For two kinds of phase it samples the address/data and command/byte-enable lines: a claimed address phase, and a completed write data phase that this target accepted. One clock after that phase it compares the parity the initiator drove. A mismatch is reported two clocks after the phase.

Data errors drive the active-low data-parity-error line, and only while the parity-response enable is set. This line is a sustained tri-state signal: after an assertion it is driven high for exactly one clock and then released. Address errors pull the open-drain system-error line low for one clock, and only when both the system-error enable and the parity-response enable are set. Every detected error produces a one-clock status pulse, whatever the enables are. A second pulse marks each signalled system error. A status register outside the block latches both pulses.

The phase qualifiers come from the transaction controller that owns decoding. The bus sets the pace, so the data path has no valid/ready handshake and no back-pressure. Each qualifier is sampled in the cycle it is high, and the parity bit must follow on the next cycle.

Top module: `pci_parity_unit`

## Requirements
- R1: While reset is held and immediately after it, `par_oe`, `perr_oe`, `serr_drive_low`, `parity_err_pulse` and `sys_err_pulse` are 0 and `perr_n_out` is 1.
- R2: When `rd_data_drive` is high in a cycle, on the next cycle `par_oe` is 1 and `par_out` equals the XOR of the 32 `bus_ad` bits and 4 `bus_cbe` bits of that cycle, so the count of ones across all 37 bits is even. `par_oe` is 0 on a cycle that follows one with `rd_data_drive` low.
- R3: A write data phase (`wr_data_xfer`=1) whose `bus_par_in` on the following cycle breaks even parity drives `perr_oe`=1, `perr_n_out`=0 two cycles after the phase when `parity_resp_en` is 1.
- R4: After `perr_n_out` is driven low, the first cycle without a new data error has `perr_oe`=1 and `perr_n_out`=1; on the cycle after that `perr_oe` is 0.
- R5: A qualified phase with correct parity produces no `parity_err_pulse`, no `perr_oe` and no `serr_drive_low`.
- R6: With `parity_resp_en`=0, a write data parity error leaves `perr_oe` at 0 but still raises `parity_err_pulse`.
- R7: An address phase (`addr_phase`=1) with bad parity, with `serr_en` and `parity_resp_en` both 1, raises `serr_drive_low` and `sys_err_pulse` for exactly one cycle, two cycles after the phase.
- R8: An address parity error with either `serr_en` or `parity_resp_en` at 0 leaves `serr_drive_low` and `sys_err_pulse` at 0 but still raises `parity_err_pulse`.
- R9: A bad `bus_par_in` that follows a cycle with neither `addr_phase` nor `wr_data_xfer` high is ignored: `parity_err_pulse` stays 0.
- R10: Each detected error raises `parity_err_pulse` for exactly one cycle, two cycles after the phase.
- R11: Write data errors on consecutive phases keep `perr_n_out` low on consecutive cycles, with no high cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad | input | 32 | Sampled address/data lines |
| bus_cbe | input | 4 | Sampled command/byte-enable lines |
| bus_par_in | input | 1 | Parity driven by the initiator, one cycle after its phase |
| addr_phase | input | 1 | Claimed address phase this cycle |
| wr_data_xfer | input | 1 | Completed write data phase this cycle |
| rd_data_drive | input | 1 | Target drives read data this cycle |
| parity_resp_en | input | 1 | Parity-error response enable (command register) |
| serr_en | input | 1 | System-error enable (command register) |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Output enable for the parity bit |
| perr_n_out | output | 1 | Data-parity-error line value, active low |
| perr_oe | output | 1 | Output enable for the data-parity-error line |
| serr_drive_low | output | 1 | Pull the open-drain system-error line low |
| parity_err_pulse | output | 1 | One-clock pulse per detected parity error |
| sys_err_pulse | output | 1 | One-clock pulse per signalled system error |

## Verification
The bench checks the two-cycle lag by sampling the error outputs on the exact cycle. A design that reports one cycle early or late fails the error checks, and one whose generated parity is one cycle late fails the read-parity check. It checks the one-clock high drive and release of the data-parity-error line, and it runs back-to-back write errors. A design without the high cycle, or one that drives a high glitch between consecutive errors, is caught there. It sweeps the enable combinations for address and data errors, so a design that gates the detect pulse by the enables, or raises the system error with only one enable set, is caught. It also drives bad parity after unqualified cycles, which catches a checker that compares on every cycle.

// File: rtl/pci_parity_pkg.sv
package pci_parity_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WDATA = 2'd2
  } phase_kind_e;

  typedef struct packed {
    logic        acc;
    phase_kind_e kind;
  } capture_t;
endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
  parameter int W    = 36,
  parameter int LANE = 8
) (
  input  logic [W-1:0] vec,
  output logic         odd
);
  localparam int LANES = (W + LANE - 1) / LANE;
  localparam int PADW  = LANES * LANE;

  logic [PADW-1:0]  padded;
  logic [LANES-1:0] lane_x;

  always_comb begin
    padded = '0;
    padded[W-1:0] = vec;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_x[g] = ^padded[g*LANE +: LANE];
  end

  assign odd = ^lane_x;
endmodule

// File: rtl/par_capture.sv
module par_capture
  import pci_parity_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_ad,
  input  logic [BE_W-1:0]   bus_cbe,
  input  logic              addr_phase,
  input  logic              wr_data_xfer,
  input  logic              rd_data_drive,
  output capture_t          cap_q,
  output logic              par_out,
  output logic              par_oe
);
  localparam int TOT_W = DATA_W + BE_W;

  logic        odd_now;
  phase_kind_e kind_now;
  logic        drive_q;

  parity_tree #(.W(TOT_W), .LANE(8)) u_tree (
    .vec ({bus_ad, bus_cbe}),
    .odd (odd_now)
  );

  always_comb begin
    if (addr_phase)        kind_now = PH_ADDR;
    else if (wr_data_xfer) kind_now = PH_WDATA;
    else                   kind_now = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '{acc: 1'b0, kind: PH_IDLE};
      drive_q <= 1'b0;
    end else begin
      cap_q   <= '{acc: odd_now, kind: kind_now};
      drive_q <= rd_data_drive;
    end
  end

  assign par_out = cap_q.acc;
  assign par_oe  = drive_q;
endmodule

// File: rtl/err_report.sv
module err_report
  import pci_parity_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  capture_t cap_q,
  input  logic     bus_par_in,
  input  logic     parity_resp_en,
  input  logic     serr_en,
  output logic     perr_n_out,
  output logic     perr_oe,
  output logic     serr_drive_low,
  output logic     parity_err_pulse,
  output logic     sys_err_pulse
);
  logic mismatch, addr_err, data_err, perr_new, serr_new;
  logic low_q, high_q, det_q, serr_q;

  assign mismatch = cap_q.acc ^ bus_par_in;
  assign addr_err = mismatch && (cap_q.kind == PH_ADDR);
  assign data_err = mismatch && (cap_q.kind == PH_WDATA);
  assign perr_new = data_err && parity_resp_en;
  assign serr_new = addr_err && parity_resp_en && serr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= 1'b0;
      high_q <= 1'b0;
      det_q  <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      low_q  <= perr_new;
      high_q <= low_q && !perr_new;
      det_q  <= addr_err || data_err;
      serr_q <= serr_new;
    end
  end

  assign perr_n_out       = !low_q;
  assign perr_oe          = low_q || high_q;
  assign serr_drive_low   = serr_q;
  assign sys_err_pulse    = serr_q;
  assign parity_err_pulse = det_q;
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_parity_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_ad,
  input  logic [BE_W-1:0]   bus_cbe,
  input  logic              bus_par_in,
  input  logic              addr_phase,
  input  logic              wr_data_xfer,
  input  logic              rd_data_drive,
  input  logic              parity_resp_en,
  input  logic              serr_en,
  output logic              par_out,
  output logic              par_oe,
  output logic              perr_n_out,
  output logic              perr_oe,
  output logic              serr_drive_low,
  output logic              parity_err_pulse,
  output logic              sys_err_pulse
);
  capture_t cap_q;

  par_capture #(.DATA_W(DATA_W), .BE_W(BE_W)) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_ad        (bus_ad),
    .bus_cbe       (bus_cbe),
    .addr_phase    (addr_phase),
    .wr_data_xfer  (wr_data_xfer),
    .rd_data_drive (rd_data_drive),
    .cap_q         (cap_q),
    .par_out       (par_out),
    .par_oe        (par_oe)
  );

  err_report u_err (
    .clk              (clk),
    .rst_n            (rst_n),
    .cap_q            (cap_q),
    .bus_par_in       (bus_par_in),
    .parity_resp_en   (parity_resp_en),
    .serr_en          (serr_en),
    .perr_n_out       (perr_n_out),
    .perr_oe          (perr_oe),
    .serr_drive_low   (serr_drive_low),
    .parity_err_pulse (parity_err_pulse),
    .sys_err_pulse    (sys_err_pulse)
  );
endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_ad,
  input logic [BE_W-1:0]   bus_cbe,
  input logic              rd_data_drive,
  input logic              parity_resp_en,
  input logic              serr_en,
  input logic              par_out,
  input logic              par_oe,
  input logic              perr_n_out,
  input logic              perr_oe,
  input logic              serr_drive_low,
  input logic              parity_err_pulse
);
  // R2
  rd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_drive |=> (par_oe && (par_out == $past(^{bus_ad, bus_cbe}))));

  // R4
  perr_hold_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out) |=> perr_oe);

  // R4
  perr_high_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && perr_n_out) |=> !(perr_oe && perr_n_out));

  // R6
  perr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out) |-> $past(parity_resp_en));

  // R8
  serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_drive_low |-> $past(serr_en && parity_resp_en));

  // R7
  serr_has_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_drive_low |-> parity_err_pulse);
endmodule

bind pci_parity_unit pci_parity_unit_chk #(.DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_ad           (bus_ad),
  .bus_cbe          (bus_cbe),
  .rd_data_drive    (rd_data_drive),
  .parity_resp_en   (parity_resp_en),
  .serr_en          (serr_en),
  .par_out          (par_out),
  .par_oe           (par_oe),
  .perr_n_out       (perr_n_out),
  .perr_oe          (perr_oe),
  .serr_drive_low   (serr_drive_low),
  .parity_err_pulse (parity_err_pulse)
);

// File: tb/pci_parity_unit_bench.sv
module pci_parity_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_ad = '0;
  logic [3:0]  bus_cbe = '0;
  logic        bus_par_in = 1'b0;
  logic        addr_phase = 1'b0, wr_data_xfer = 1'b0, rd_data_drive = 1'b0;
  logic        parity_resp_en = 1'b0, serr_en = 1'b0;
  logic        par_out, par_oe, perr_n_out, perr_oe, serr_drive_low;
  logic        parity_err_pulse, sys_err_pulse;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pci_parity_unit u_pci_parity_unit (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // {perr_oe, perr_n_out, serr_drive_low, parity_err_pulse}
  function automatic logic [3:0] errs();
    return {perr_oe, perr_n_out, serr_drive_low, parity_err_pulse};
  endfunction

  // One qualified phase; returns after the cycle where errors appear.
  task automatic phase(input bit is_addr, input logic [31:0] ad,
                       input logic [3:0] cbe, input bit good);
    step();
    bus_ad = ad; bus_cbe = cbe;
    addr_phase = is_addr; wr_data_xfer = !is_addr;
    step();
    addr_phase = 1'b0; wr_data_xfer = 1'b0;
    bus_par_in = (^{ad, cbe}) ^ !good;
    bus_ad = ~ad;
    step();
    bus_par_in = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {par_oe, errs()} == 5'b00100 ? 4'd1 : 4'd0, 4'd1);
    chk("R1 sys pulse", {3'b0, sys_err_pulse}, 4'd0);
  endtask

  task automatic t_read_parity();
    logic [31:0] v[3] = '{32'h0000_0000, 32'hDEAD_BEEF, 32'h8000_0001};
    for (int i = 0; i < 3; i++) begin
      step();
      bus_ad = v[i]; bus_cbe = 4'(i + 5); rd_data_drive = 1'b1;
      step();
      rd_data_drive = 1'b0;
      chk("R2 par_out", {3'b0, par_out}, {3'b0, ^{v[i], 4'(i + 5)}});
      chk("R2 par_oe on", {3'b0, par_oe}, 4'd1);
      step();
      chk("R2 par_oe off", {3'b0, par_oe}, 4'd0);
    end
  endtask

  task automatic t_good_parity();
    parity_resp_en = 1; serr_en = 1;
    phase(0, 32'h1234_5678, 4'h0, 1);
    chk("R5 good write", errs(), 4'b0100);
    phase(1, 32'hFFFF_0000, 4'h7, 1);
    chk("R5 good address", errs(), 4'b0100);
  endtask

  task automatic t_data_err();
    parity_resp_en = 1;
    phase(0, 32'hA5A5_0F0F, 4'h3, 0);
    chk("R3 perr low", errs(), 4'b1001);
    step();
    chk("R4 perr high drive", errs(), 4'b1100);
    chk("R10 pulse single", {3'b0, parity_err_pulse}, 4'd0);
    step();
    chk("R4 perr released", errs(), 4'b0100);
  endtask

  task automatic t_data_err_disabled();
    parity_resp_en = 0;
    phase(0, 32'h0F0F_0001, 4'hC, 0);
    chk("R6 no perr, pulse", errs(), 4'b0101);
    parity_resp_en = 1;
  endtask

  task automatic t_addr_err();
    parity_resp_en = 1; serr_en = 1;
    phase(1, 32'h4000_0010, 4'h6, 0);
    chk("R7 serr low", errs(), 4'b0111);
    chk("R7 sys pulse", {3'b0, sys_err_pulse}, 4'd1);
    step();
    chk("R7 serr one cycle", {2'b0, serr_drive_low, sys_err_pulse}, 4'd0);
    for (int m = 0; m < 3; m++) begin
      serr_en = m[0]; parity_resp_en = m[1];
      phase(1, 32'h4000_0020 + m, 4'h7, 0);
      chk("R8 gated serr", {serr_drive_low, sys_err_pulse, 1'b0, parity_err_pulse}, 4'b0001);
    end
    parity_resp_en = 1; serr_en = 1;
  endtask

  task automatic t_unqualified();
    step();
    bus_ad = 32'h0000_0007; bus_cbe = 4'h0;
    step();
    bus_par_in = 1'b0;
    step();
    chk("R9 ignored", errs(), 4'b0100);
    step();
    chk("R9 ignored next", errs(), 4'b0100);
  endtask

  task automatic t_back_to_back();
    parity_resp_en = 1;
    step();
    bus_ad = 32'h1; bus_cbe = 4'h0; wr_data_xfer = 1;
    step();
    bus_par_in = 1'b0; bus_ad = 32'h3; bus_cbe = 4'h1;
    step();
    wr_data_xfer = 0; bus_par_in = 1'b0;
    chk("R11 first low", {perr_oe, perr_n_out, 2'b0}, 4'b1000);
    step();
    chk("R11 second low", {perr_oe, perr_n_out, 2'b0}, 4'b1000);
    step();
    chk("R11 then high", {perr_oe, perr_n_out, 2'b0}, 4'b1100);
    step();
    chk("R11 released", {3'b0, perr_oe}, 4'd0);
  endtask

  initial begin
    step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_read_parity();
    t_good_parity();
    t_data_err();
    t_data_err_disabled();
    t_addr_err();
    t_unqualified();
    t_back_to_back();
    step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule